// File: doc/BRIEF.md
# Stepper Following-Error Corrector

This block keeps an open-loop stepper motor aligned with its shaft encoder by tracking the difference between commanded motion and measured motion in one narrow error counter. The counter starts at its midpoint. Each commanded step moves the counter by a programmable command weight. Each decoded encoder count moves it the other way by a programmable encoder weight. The sign of both depends on the direction of rotation. Choosing the two weights as small integers in the ratio of encoder counts per step lets one counter serve any integer-expressible ratio. For example, 2.5 counts per step gives a command weight of 5 and an encoder weight of 2.

When the counter drifts past an upper threshold, the motor has fallen behind in the clockwise sense, and the block emits one clockwise correction step. When the counter falls below a lower threshold, the block emits one counter-clockwise correction step. After each correction the block stays quiet for a programmable hold interval. This gives the motor time to move and the encoder counts time to arrive before the thresholds are looked at again. The counter clamps at its two ends instead of wrapping, and a rail flag reports when it sits at either end. Step and encoder inputs are single-cycle pulses that are already synchronous to the block clock.

Top module: `sfc_follow_corrector`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `err_count` is 128 (half of the 8-bit range), `corr_step` is 0, `corr_dir` is 0 and `err_rail` is 0.
- R2: A `cmd_step` pulse with `cmd_dir`=0 (clockwise) raises `err_count` by `cmd_wt` on the next clock. With `cmd_dir`=1 (counter-clockwise) it lowers `err_count` by `cmd_wt`.
- R3: An `enc_cnt` pulse with `enc_dir`=0 (clockwise) lowers `err_count` by `enc_wt` on the next clock. With `enc_dir`=1 it raises `err_count` by `enc_wt`.
- R4: A command pulse and an encoder pulse in the same cycle are combined into one update of `err_count` that equals the sum of both signed weights.
- R5: `err_count` never wraps. It clamps at 0 and at 255, and `err_rail` is 1 exactly when `err_count` is 0 or 255.
- R6: When the block is idle and `err_count` is at or above `hi_thr`, a one-cycle `corr_step` pulse with `corr_dir`=0 (clockwise) appears on the next clock. Clockwise wins if both threshold conditions hold.
- R7: When the block is idle and `err_count` is below `lo_thr` (and not at or above `hi_thr`), a one-cycle `corr_step` pulse with `corr_dir`=1 (counter-clockwise) appears on the next clock.
- R8: The block is idle only when `corr_step` is low and at least `hold_len` cycles have passed since the last pulse. Two correction pulses are therefore separated by at least `hold_len`+1 cycles.
- R9: Correction pulses do not change `err_count`. Without command or encoder pulses, `err_count` holds its value.
- R10: With weights 5 and 2, 24 commanded clockwise steps without any encoder count leave `err_count` at 248 with `err_rail` low. The counter can then still come back without loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_step | input | 1 | One-cycle commanded step pulse |
| cmd_dir | input | 1 | Command direction, 0 clockwise, 1 counter-clockwise |
| enc_cnt | input | 1 | One-cycle decoded encoder count pulse |
| enc_dir | input | 1 | Encoder direction, 0 clockwise, 1 counter-clockwise |
| cmd_wt | input | WT_W | Weight applied per commanded step |
| enc_wt | input | WT_W | Weight applied per encoder count |
| hi_thr | input | CNT_W | Counter value at or above which a clockwise correction is issued |
| lo_thr | input | CNT_W | Counter value below which a counter-clockwise correction is issued |
| hold_len | input | HOLD_W | Quiet cycles required after each correction |
| corr_step | output | 1 | One-cycle correction step pulse |
| corr_dir | output | 1 | Direction of the last correction, 0 clockwise |
| err_count | output | CNT_W | Offset-binary following-error counter |
| err_rail | output | 1 | Counter is clamped at 0 or at full scale |

## Verification
An input pulse presented in cycle t changes `err_count` and `err_rail` in cycle t+1. A correction pulse is decided from the counter value of cycle t+1 and shows on `corr_step` in cycle t+2, so it lags the causing event by two clocks. The bench drives all inputs on the falling edge and advances its behavioural model once per rising edge from the same inputs. It compares every output at the following falling edge, so each result is read in the cycle it is due. Directed checks are made at those same instants and cover the exact counter values after single, combined, clamped and 24-step sequences.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  typedef enum logic {
    ROT_CW  = 1'b0,
    ROT_CCW = 1'b1
  } rot_e;

  // Signed contribution of one event. adds_on_cw selects whether a
  // clockwise event increases (command) or decreases (encoder) the error.
  function automatic int event_weight(logic fire, logic ccw, int wt, logic adds_on_cw);
    int mag;
    mag = fire ? wt : 0;
    return (adds_on_cw != ccw) ? mag : -mag;
  endfunction

  function automatic int clamp_range(int v, int lo, int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/sfc_event_weight.sv
module sfc_event_weight #(
  parameter int WT_W = 4,
  localparam int DW  = WT_W + 2
) (
  input  logic                 cmd_step,
  input  logic                 cmd_dir,
  input  logic                 enc_cnt,
  input  logic                 enc_dir,
  input  logic [WT_W-1:0]      cmd_wt,
  input  logic [WT_W-1:0]      enc_wt,
  output logic signed [DW-1:0] delta
);
  import sfc_pkg::*;

  int cmd_part;
  int enc_part;

  always_comb begin
    cmd_part = event_weight(cmd_step, cmd_dir, int'(cmd_wt), 1'b1);
    enc_part = event_weight(enc_cnt, enc_dir, int'(enc_wt), 1'b0);
    delta    = DW'(cmd_part + enc_part);
  end

endmodule

// File: rtl/sfc_err_accum.sv
module sfc_err_accum #(
  parameter int CNT_W = 8,
  parameter int DW    = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] delta,
  output logic [CNT_W-1:0]     count,
  output logic                 at_rail
);
  import sfc_pkg::*;

  localparam int                MAX_I = (1 << CNT_W) - 1;
  localparam logic [CNT_W-1:0]  MID   = CNT_W'(1 << (CNT_W - 1));
  localparam logic [CNT_W-1:0]  TOP   = CNT_W'(MAX_I);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;
  int               sum;

  always_comb begin
    sum     = clamp_range(int'(count_q) + int'(delta), 0, MAX_I);
    count_d = CNT_W'(sum);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count_q <= MID;
    else        count_q <= count_d;
  end

  assign count   = count_q;
  assign at_rail = (count_q == '0) || (count_q == TOP);

  assert_top_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == TOP && delta > 0) |=> (count_q == TOP));

  assert_floor_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == '0 && delta < 0) |=> (count_q == '0));

endmodule

// File: rtl/sfc_corr_gen.sv
module sfc_corr_gen #(
  parameter int CNT_W  = 8,
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  hi_thr,
  input  logic [CNT_W-1:0]  lo_thr,
  input  logic [HOLD_W-1:0] hold_len,
  output logic              corr_step,
  output logic              corr_dir
);
  import sfc_pkg::*;

  logic              step_q;
  rot_e              dir_q;
  logic [HOLD_W-1:0] hold_q;

  logic want_cw;
  logic want_ccw;
  logic idle;
  logic fire;
  rot_e fire_dir;

  assign want_cw  = (count >= hi_thr);
  assign want_ccw = (count < lo_thr);
  assign idle     = !step_q && (hold_q == '0);
  assign fire     = idle && (want_cw || want_ccw);
  assign fire_dir = want_cw ? ROT_CW : ROT_CCW;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= 1'b0;
      dir_q  <= ROT_CW;
      hold_q <= '0;
    end else if (fire) begin
      step_q <= 1'b1;
      dir_q  <= fire_dir;
      hold_q <= hold_len;
    end else begin
      step_q <= 1'b0;
      if (hold_q != '0) hold_q <= hold_q - 1'b1;
    end
  end

  assign corr_step = step_q;
  assign corr_dir  = dir_q;

  // Independent spacing monitor for the assertions below.
  logic [HOLD_W:0] since_q;
  logic [HOLD_W:0] need_q;
  logic            seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_q <= '0;
      need_q  <= '0;
      seen_q  <= 1'b0;
    end else if (fire) begin
      since_q <= '0;
      need_q  <= {1'b0, hold_len} + (HOLD_W+1)'(1);
      seen_q  <= 1'b1;
    end else if (since_q != '1) begin
      since_q <= since_q + 1'b1;
    end
  end

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step_q |=> !step_q);

  assert_pulse_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && seen_q) |-> (since_q + 1'b1 >= need_q));

endmodule

// File: rtl/sfc_follow_corrector.sv
module sfc_follow_corrector #(
  parameter int CNT_W  = 8,
  parameter int WT_W   = 4,
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_step,
  input  logic              cmd_dir,
  input  logic              enc_cnt,
  input  logic              enc_dir,
  input  logic [WT_W-1:0]   cmd_wt,
  input  logic [WT_W-1:0]   enc_wt,
  input  logic [CNT_W-1:0]  hi_thr,
  input  logic [CNT_W-1:0]  lo_thr,
  input  logic [HOLD_W-1:0] hold_len,
  output logic              corr_step,
  output logic              corr_dir,
  output logic [CNT_W-1:0]  err_count,
  output logic              err_rail
);
  localparam int DW = WT_W + 2;

  logic signed [DW-1:0] ev_delta;

  sfc_event_weight #(.WT_W(WT_W)) u_weight (
    .cmd_step (cmd_step),
    .cmd_dir  (cmd_dir),
    .enc_cnt  (enc_cnt),
    .enc_dir  (enc_dir),
    .cmd_wt   (cmd_wt),
    .enc_wt   (enc_wt),
    .delta    (ev_delta)
  );

  sfc_err_accum #(.CNT_W(CNT_W), .DW(DW)) u_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .delta   (ev_delta),
    .count   (err_count),
    .at_rail (err_rail)
  );

  sfc_corr_gen #(.CNT_W(CNT_W), .HOLD_W(HOLD_W)) u_corr (
    .clk       (clk),
    .rst_n     (rst_n),
    .count     (err_count),
    .hi_thr    (hi_thr),
    .lo_thr    (lo_thr),
    .hold_len  (hold_len),
    .corr_step (corr_step),
    .corr_dir  (corr_dir)
  );

  assert_cw_when_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_step && !corr_dir) |-> ($past(err_count) >= $past(hi_thr)));

  assert_ccw_when_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_step && corr_dir) |-> ($past(err_count) < $past(lo_thr)));

  assert_quiet_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_step && !enc_cnt) |=> $stable(err_count));

endmodule

// File: tb/sim_sfc_follow_corrector.sv
module sim_sfc_follow_corrector;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_step = 0, cmd_dir = 0, enc_cnt = 0, enc_dir = 0;
  logic [3:0] cmd_wt = 4'd5, enc_wt = 4'd2;
  logic [7:0] hi_thr = 8'd255, lo_thr = 8'd0;
  logic [7:0] hold_len = 8'd4;
  logic       corr_step, corr_dir, err_rail;
  logic [7:0] err_count;

  always #10 clk = ~clk;

  sfc_follow_corrector u0 (
    .clk(clk), .rst_n(rst_n), .cmd_step(cmd_step), .cmd_dir(cmd_dir),
    .enc_cnt(enc_cnt), .enc_dir(enc_dir), .cmd_wt(cmd_wt), .enc_wt(enc_wt),
    .hi_thr(hi_thr), .lo_thr(lo_thr), .hold_len(hold_len),
    .corr_step(corr_step), .corr_dir(corr_dir),
    .err_count(err_count), .err_rail(err_rail)
  );

  int vectors = 0;
  int errors  = 0;
  string cur_req = "R1";

  // behavioural reference
  int m_cnt, m_quiet, m_step, m_dir, m_last;

  task automatic check(string tag, int act, int exp, string what);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cnt = 128; m_quiet = 0; m_step = 0; m_dir = 0;
  endtask

  task automatic model_clock();
    int d, nxt;
    d = 0;
    if (cmd_step) d = d + (cmd_dir ? -int'(cmd_wt) : int'(cmd_wt));
    if (enc_cnt)  d = d + (enc_dir ? int'(enc_wt) : -int'(enc_wt));
    nxt = m_cnt + d;
    if (nxt > 255) nxt = 255;
    if (nxt < 0)   nxt = 0;
    if (m_step == 0 && m_quiet == 0 && (m_cnt >= int'(hi_thr) || m_cnt < int'(lo_thr))) begin
      m_dir   = (m_cnt >= int'(hi_thr)) ? 0 : 1;
      m_step  = 1;
      m_quiet = int'(hold_len);
    end else begin
      m_step = 0;
      if (m_quiet > 0) m_quiet--;
    end
    m_cnt = nxt;
  endtask

  task automatic compare_all();
    vectors++;
    if (err_count != 8'(m_cnt) || corr_step != m_step[0] || corr_dir != m_dir[0] ||
        err_rail != (m_cnt == 0 || m_cnt == 255)) begin
      errors++;
      $display("FAIL %s: actual cnt=%0d step=%0d dir=%0d rail=%0d expected cnt=%0d step=%0d dir=%0d rail=%0d at %0t",
               cur_req, err_count, corr_step, corr_dir, err_rail,
               m_cnt, m_step, m_dir, (m_cnt == 0 || m_cnt == 255), $time);
    end
  endtask

  // one cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(logic c, logic cd, logic e, logic ed);
    cmd_step = c; cmd_dir = cd; enc_cnt = e; enc_dir = ed;
    @(posedge clk);
    model_clock();
    @(negedge clk);
    cmd_step = 0; enc_cnt = 0;
    compare_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; cmd_step = 0; enc_cnt = 0;
    repeat (2) @(posedge clk);
    model_reset();
    @(negedge clk);
    cur_req = "R1";
    compare_all();
    rst_n = 1;
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset values
    check("R1", int'(err_count), 128, "count after reset");
    check("R1", int'(corr_step), 0, "step after reset");
    check("R1", int'(err_rail), 0, "rail after reset");

    // R2 / R3 / R4 with corrections parked (hi=255, lo=0)
    cur_req = "R2";
    cyc(1, 0, 0, 0); check("R2", int'(err_count), 133, "cw command");
    cyc(1, 1, 0, 0); check("R2", int'(err_count), 128, "ccw command");
    cur_req = "R3";
    cyc(0, 0, 1, 0); check("R3", int'(err_count), 126, "cw encoder");
    cyc(0, 0, 1, 1); check("R3", int'(err_count), 128, "ccw encoder");
    cur_req = "R4";
    cyc(1, 0, 1, 0); check("R4", int'(err_count), 131, "joint cw");
    cyc(1, 1, 1, 1); check("R4", int'(err_count), 128, "joint ccw");

    // R10: 24 missed steps stay inside the range
    cur_req = "R10";
    for (int i = 0; i < 24; i++) cyc(1, 0, 0, 0);
    check("R10", int'(err_count), 248, "after 24 steps");
    check("R10", int'(err_rail), 0, "rail after 24 steps");

    // R5: clamp at both ends
    cur_req = "R5";
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0);
    check("R5", int'(err_count), 255, "upper clamp");
    check("R5", int'(err_rail), 1, "upper rail");
    idle(3);
    for (int i = 0; i < 60; i++) cyc(1, 1, 0, 0);
    check("R5", int'(err_count), 0, "lower clamp");
    cyc(0, 0, 1, 0);
    check("R5", int'(err_count), 0, "no wrap below zero");
    check("R5", int'(err_rail), 1, "lower rail");

    // R6 / R9: clockwise corrections, counter untouched by them
    hi_thr = 8'd130; lo_thr = 8'd126; hold_len = 8'd4;
    do_reset();
    cur_req = "R6";
    cyc(1, 0, 0, 0);
    idle(1);
    check("R6", int'(corr_step), 1, "cw correction pulse");
    check("R6", int'(corr_dir), 0, "cw correction direction");
    cur_req = "R9";
    idle(12);
    check("R9", int'(err_count), 133, "count unchanged by corrections");
    cur_req = "R3";
    cyc(0, 0, 1, 0); cyc(0, 0, 1, 0);
    idle(6);

    // R7: counter-clockwise corrections
    cur_req = "R7";
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0);
    check("R7", int'(err_count), 123, "below lower threshold");
    idle(10);

    // R8: different hold lengths
    cur_req = "R8";
    hold_len = 8'd0; idle(8);
    hold_len = 8'd9; idle(25);

    // mixed stimulus against the model
    cur_req = "R4";
    for (int blk = 0; blk < 15; blk++) begin
      cmd_wt   = 4'($urandom_range(1, 15));
      enc_wt   = 4'($urandom_range(1, 15));
      lo_thr   = 8'($urandom_range(60, 128));
      hi_thr   = 8'($urandom_range(129, 200));
      hold_len = 8'($urandom_range(0, 15));
      if (blk == 7) do_reset();
      cur_req = (blk % 2 == 0) ? "R8" : "R5";
      for (int i = 0; i < 200; i++)
        cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule